// File: doc/BRIEF.md
# Split Decade Counter with Nine-Preset

This block counts to ten in two independent sections that run from one system clock. A divide-by-two section holds the low output bit. A divide-by-five section holds the upper three bits. Each section has its own count input. The block samples both count inputs with the system clock, and a section steps once for each high-to-low transition it detects on its own input.

A two-bit strap input joins the sections internally. In BCD strapping, the wrap of the low bit drives the upper section, so counts applied to the first input give a plain decimal sequence. In bi-quinary strapping, the wrap of the upper section drives the low bit, so counts applied to the second input give a low bit that is a square wave at one tenth of the count rate with a 50% duty cycle.

Two AND-gated override pairs act at the level of the system clock:
- One pair clears the outputs to zero.
- The other pair presets them to nine and wins over the clear pair.

Top module: `dec_counter`

## Requirements
- R1: While rstN is low, qOut is 4'b0000. qOut is {QD, QC, QB, QA} with QA at bit 0.
- R2: With strapMode 2'b00, each detected falling edge of cntA inverts qOut[0], and each detected falling edge of cntB advances qOut[3:1]. The reserved strap code 2'b11 behaves the same as 2'b00.
- R3: qOut[3:1] steps in binary through 0, 1, 2, 3, 4 and then returns from 4 to 0. It never holds a value above 4.
- R4: With strapMode 2'b01 (BCD), falling edges of cntA make qOut step through 0 to 9 in binary and then return to 0. Edges on cntB have no effect in this mode.
- R5: With strapMode 2'b10 (bi-quinary), falling edges of cntB step qOut[3:1] through 0 to 4 with qOut[0] low, and then through 0 to 4 again with qOut[0] high. Edges on cntA have no effect in this mode.
- R6: When both bits of clrPair are high and ninePair is not 2'b11, qOut becomes 4'b0000 and count edges are ignored.
- R7: When both bits of ninePair are high, qOut becomes 4'b1001 and count edges are ignored, whatever the state of clrPair.
- R8: When at least one bit of each pair is low, counting proceeds normally.
- R9: Rising edges of the count inputs never change qOut. A falling edge shows at qOut after the third rising clock edge that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cntA | input | 1 | Count input of the divide-by-two section |
| cntB | input | 1 | Count input of the divide-by-five section |
| clrPair | input | 2 | Gated clear-to-zero pair |
| ninePair | input | 2 | Gated preset-to-nine pair |
| strapMode | input | 2 | 00 split, 01 BCD, 10 bi-quinary, 11 as split |
| qOut | output | 4 | Count value {QD, QC, QB, QA} |

## Verification
The whole state of this block sits on qOut, so a corrupted count shows at the ports as soon as the next count edge takes effect. Typical symptoms are a wrong successor value, a quinary value of 5 or more, or a wrap in the wrong place. A strapping fault shows up one count later: the downstream bit either fails to move on the upstream wrap, or it moves on an edge that should have been ignored. A fault in an override shows within three clock cycles, as a value other than 0000 or 1001.

// File: rtl/dc_pkg.sv
package dc_pkg;
  localparam int QUI_W = 3;
  localparam logic [QUI_W-1:0] QUI_TOP = 3'd4;
  localparam logic [1:0] MODE_SPLIT = 2'b00;
  localparam logic [1:0] MODE_BCD   = 2'b01;
  localparam logic [1:0] MODE_BIQ   = 2'b10;

  typedef struct packed {
    logic advA;
    logic advB;
    logic clr;
    logic nine;
  } dcStrobe_t;
endpackage

// File: rtl/dc_ctrl.sv
module dc_ctrl
  import dc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NUM_CH = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cntA,
  input  logic            cntB,
  input  logic [1:0]      clrPair,
  input  logic [1:0]      ninePair,
  input  logic [1:0]      strapMode,
  input  logic            qaNow,
  input  logic            qdNow,
  output dcStrobe_t       strb
);
  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic [NUM_CH-1:0] rawIn;
  logic [NUM_CH-1:0] fallDet;

  assign rawIn = {cntB, cntA};

  // Per-channel synchronizer plus one history flop for edge detection.
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_sync
    logic [CHAIN_W-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[CHAIN_W-2:0], rawIn[ch]};
    end
    assign fallDet[ch] = chain[CHAIN_W-1] & ~chain[CHAIN_W-2];
  end

  logic nineOn, clrOn, ovrOn;
  assign nineOn = &ninePair;
  assign clrOn  = (&clrPair) & ~nineOn;
  assign ovrOn  = nineOn | (&clrPair);

  logic advA, advB;
  always_comb begin
    unique case (strapMode)
      MODE_BCD: begin
        advA = fallDet[0];
        advB = fallDet[0] & qaNow;     // QA about to wrap 1->0
      end
      MODE_BIQ: begin
        advB = fallDet[1];
        advA = fallDet[1] & qdNow;     // quinary about to wrap 4->0
      end
      default: begin
        advA = fallDet[0];
        advB = fallDet[1];
      end
    endcase
  end

  assign strb.advA = advA & ~ovrOn;
  assign strb.advB = advB & ~ovrOn;
  assign strb.clr  = clrOn;
  assign strb.nine = nineOn;

  // R6 / R7: no count strobe passes while an override pair is fully asserted
  a_r7_override_blocks: assert property (@(posedge clk) disable iff (!rstN)
    ((&clrPair) || (&ninePair)) |-> (!strb.advA && !strb.advB));

  // R9: a detected fall must come from an input that was high before
  a_r9_fall_only: assert property (@(posedge clk) disable iff (!rstN)
    (strapMode == MODE_SPLIT && strb.advA) |-> !g_sync[0].chain[CHAIN_W-2]);
endmodule

// File: rtl/dc_datapath.sv
module dc_datapath
  import dc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dcStrobe_t  strb,
  output logic [3:0] qOut
);
  logic             qaBit;
  logic [QUI_W-1:0] quiState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          qaBit <= 1'b0;
    else if (strb.nine) qaBit <= 1'b1;
    else if (strb.clr)  qaBit <= 1'b0;
    else if (strb.advA) qaBit <= ~qaBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          quiState <= '0;
    else if (strb.nine) quiState <= QUI_TOP;
    else if (strb.clr)  quiState <= '0;
    else if (strb.advB) quiState <= (quiState == QUI_TOP) ? '0 : quiState + 1'b1;
  end

  assign qOut = {quiState, qaBit};

  // R3: quinary value stays inside 0..4
  a_r3_quinary_range: assert property (@(posedge clk) disable iff (!rstN)
    quiState <= QUI_TOP);

  // R6: a clear strobe zeroes the outputs
  a_r6_clear: assert property (@(posedge clk) disable iff (!rstN)
    strb.clr |=> (qOut == 4'b0000));

  // R7: a preset strobe yields nine
  a_r7_nine: assert property (@(posedge clk) disable iff (!rstN)
    strb.nine |=> (qOut == 4'b1001));

  // R8: with no strobe at all the outputs hold
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.advA && !strb.advB && !strb.clr && !strb.nine) |=> $stable(qOut));
endmodule

// File: rtl/dec_counter.sv
module dec_counter
  import dc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cntA,
  input  logic       cntB,
  input  logic [1:0] clrPair,
  input  logic [1:0] ninePair,
  input  logic [1:0] strapMode,
  output logic [3:0] qOut
);
  dcStrobe_t strb;

  dc_ctrl #(.SYNC_STAGES(2), .NUM_CH(2)) u_ctrl (
    .clk(clk), .rstN(rstN), .cntA(cntA), .cntB(cntB),
    .clrPair(clrPair), .ninePair(ninePair), .strapMode(strapMode),
    .qaNow(qOut[0]), .qdNow(qOut[3]), .strb(strb)
  );

  dc_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .qOut(qOut)
  );
endmodule

// File: tb/dec_counter_bench.sv
module dec_counter_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cntA = 1'b1;
  logic       cntB = 1'b1;
  logic [1:0] clrPair = 2'b00;
  logic [1:0] ninePair = 2'b00;
  logic [1:0] strapMode = 2'b00;
  logic [3:0] qOut;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dec_counter u_dec_counter (
    .clk(clk), .rstN(rstN), .cntA(cntA), .cntB(cntB),
    .clrPair(clrPair), .ninePair(ninePair), .strapMode(strapMode), .qOut(qOut)
  );

  task automatic chk(input string req, input logic [3:0] exp);
    checks++;
    if (qOut !== exp) begin
      fails++;
      $display("FAIL %s: qOut=%b expected=%b", req, qOut, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseA();
    cntA = 1'b0; idle(4); cntA = 1'b1; idle(4);
  endtask

  task automatic pulseB();
    cntB = 1'b0; idle(4); cntB = 1'b1; idle(4);
  endtask

  task automatic doClear();
    clrPair = 2'b11; idle(2); clrPair = 2'b00; idle(2);
  endtask

  task automatic t_reset();
    idle(3);
    chk("R1 reset", 4'b0000);
    rstN = 1'b1; idle(4);
    chk("R1 after release", 4'b0000);
  endtask

  task automatic t_split();
    strapMode = 2'b00;
    pulseA(); chk("R2 A toggles up", 4'b0001);
    pulseA(); chk("R2 A toggles down", 4'b0000);
    for (int i = 1; i <= 5; i++) begin
      pulseB();
      chk("R3 quinary step", {3'(i % 5), 1'b0});
    end
    strapMode = 2'b11;
    pulseB(); chk("R2 reserved mode counts B", 4'b0010);
    pulseA(); chk("R2 reserved mode counts A", 4'b0011);
    strapMode = 2'b00;
    doClear();
  endtask

  task automatic t_latency();
    strapMode = 2'b00;
    cntA = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    chk("R9 not yet after two edges", 4'b0000);
    @(posedge clk); #1;
    chk("R9 visible after third edge", 4'b0001);
    idle(4);
    cntA = 1'b1; idle(6);
    chk("R9 rising edge ignored", 4'b0001);
    doClear();
  endtask

  task automatic t_overrides();
    pulseA(); pulseB();
    chk("R8 counting", 4'b0011);
    clrPair = 2'b11; idle(3);
    chk("R6 clear", 4'b0000);
    pulseA(); pulseB();
    chk("R6 counts ignored during clear", 4'b0000);
    clrPair = 2'b01; idle(2);
    pulseA();
    chk("R8 half clear pair counts", 4'b0001);
    clrPair = 2'b11; ninePair = 2'b11; idle(3);
    chk("R7 nine beats clear", 4'b1001);
    clrPair = 2'b00; pulseA(); pulseB();
    chk("R7 counts ignored during nine", 4'b1001);
    ninePair = 2'b10; idle(2);
    pulseB();
    chk("R8 half nine pair counts", 4'b0001);
    ninePair = 2'b00;
    doClear();
  endtask

  task automatic t_bcd();
    strapMode = 2'b01;
    for (int i = 1; i <= 10; i++) begin
      pulseA();
      chk("R4 bcd step", 4'(i % 10));
    end
    pulseA(); pulseB();
    chk("R4 B ignored in bcd", 4'b0001);
    ninePair = 2'b11; idle(3); ninePair = 2'b00; idle(2);
    pulseA();
    chk("R4 nine wraps to zero", 4'b0000);
  endtask

  task automatic t_biq();
    strapMode = 2'b10;
    doClear();
    for (int i = 1; i <= 10; i++) begin
      pulseB();
      chk("R5 biquinary step", {3'(i % 5), 1'((i / 5) % 2)});
    end
    pulseA();
    chk("R5 A ignored in biquinary", 4'b0000);
  endtask

  initial begin
    t_reset();
    t_split();
    t_latency();
    t_overrides();
    t_bcd();
    t_biq();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule